// File: doc/BRIEF.md
# Signed Scaled Binary-to-BCD Converter

This block turns a raw sample word into four decimal digits for display or logging. A 16-bit word arrives at the input, but only its low 10 bits carry the sample. Those 10 bits are read as a two's-complement number. The block multiplies the magnitude of that number by four and writes the result as four BCD digits. A separate flag marks negative samples. The 10-bit field also leaves the block unchanged on its own port, so that a consumer can check it against the digits.

The block is purely combinational, with no clock and no state. The magnitude goes through a sign stage, then a fixed left shift for the scaling, then an unrolled shift-and-add-three network that produces the digits. The most negative code, 512, has no positive counterpart in 10 bits. The block forces it to all-zero digits and does not flag it as negative, so zero is never shown with a minus sign.

Top module: `sbcd_conv`

## Requirements
- R1: `field_out` always equals `sample_in[9:0]`.
- R2: For a field code c from 0 to 511, the decimal value of the digits (thousands*1000 + hundreds*100 + tens*10 + ones) equals 4*c, and `neg_out` is 0.
- R3: For a field code c from 513 to 1023, the decimal value of the digits equals 4*(1024 - c), which is four times the magnitude.
- R4: For field code 512, all four digits are 0 and `neg_out` is 0.
- R5: `neg_out` is 1 exactly when the field code is from 513 to 1023. Field bit 9 is the sign bit, and 512 is the only code with bit 9 set that is excluded.
- R6: Each digit is plain 4-bit binary in the range 0 to 9, and `dig_thousands` never exceeds 2. The largest result is 2044, for codes 511 and 513.
- R7: Bits [15:10] of `sample_in` have no effect on any output.
- R8: For any known input, no output bit is X or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sample_in | input | 16 | Raw sample word; only bits [9:0] are used |
| field_out | output | 10 | Retained 10-bit two's-complement field |
| dig_ones | output | 4 | BCD ones digit of 4*abs(value) |
| dig_tens | output | 4 | BCD tens digit |
| dig_hundreds | output | 4 | BCD hundreds digit |
| dig_thousands | output | 4 | BCD thousands digit (0 to 2) |
| neg_out | output | 1 | High for a negative, nonzero-magnitude sample |

## Verification
Mistakes in the digit network tend to show up only at a few magnitudes, where a digit passes through 5 during one specific shift step. A handful of chosen values can therefore miss them. The bench sweeps every field code in both the positive and the negative half. For each code it compares the rebuilt decimal value, the range of each digit and the sign flag against a model derived only from the requirements. The hardest case to reach from the ports is a change in the ignored upper bits that leaves the field the same. The bench drives several upper-bit patterns on top of boundary codes and checks that every output is identical to the result with those bits cleared.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned BCD_W    = 4;
  localparam int unsigned BCD_ADJ  = 3;
  localparam int unsigned BCD_TRIG = 5;
  typedef logic [BCD_W-1:0] bcd_digit_t;
endpackage

// File: rtl/sbcd_field_sign.sv
module sbcd_field_sign #(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned FIELD_W = 10,
  localparam int unsigned MAG_W  = FIELD_W - 1
) (
  input  logic [IN_W-1:0]    word_in,
  output logic [FIELD_W-1:0] field,
  output logic               is_neg,
  output logic               is_min,
  output logic [MAG_W-1:0]   mag
);
  localparam logic [FIELD_W-1:0] MIN_CODE = {1'b1, {MAG_W{1'b0}}};

  logic [IN_W-FIELD_W-1:0] unused_hi;
  logic [FIELD_W-1:0]      negated;

  assign field     = word_in[FIELD_W-1:0];
  assign unused_hi = word_in[IN_W-1:FIELD_W];

  always_comb begin
    negated = (~field) + {{(FIELD_W-1){1'b0}}, 1'b1};
    is_min  = (field == MIN_CODE);
    is_neg  = field[FIELD_W-1] && !is_min;
    if (field[FIELD_W-1]) mag = negated[MAG_W-1:0];
    else                  mag = field[MAG_W-1:0];
  end
endmodule

// File: rtl/sbcd_scale.sv
module sbcd_scale #(
  parameter int unsigned MAG_W  = 9,
  parameter int unsigned SHIFT  = 2,
  localparam int unsigned BIN_W = MAG_W + SHIFT
) (
  input  logic [MAG_W-1:0] mag,
  input  logic             force_zero,
  output logic [BIN_W-1:0] scaled
);
  always_comb begin
    if (force_zero) scaled = '0;
    else            scaled = {mag, {SHIFT{1'b0}}};
  end
endmodule

// File: rtl/sbcd_dabble.sv
module sbcd_dabble
  import bcd_pkg::*;
#(
  parameter int unsigned BIN_W  = 11,
  parameter int unsigned DIGITS = 4,
  localparam int unsigned OUT_W = DIGITS * BCD_W
) (
  input  logic [BIN_W-1:0] bin,
  output logic [OUT_W-1:0] bcd
);
  logic [OUT_W-1:0] stage [BIN_W+1];

  assign stage[0] = '0;

  for (genvar s = 0; s < BIN_W; s++) begin : g_step
    logic [OUT_W-1:0] adj;
    for (genvar d = 0; d < DIGITS; d++) begin : g_dig
      assign adj[d*BCD_W +: BCD_W] =
        (stage[s][d*BCD_W +: BCD_W] >= BCD_W'(BCD_TRIG))
          ? stage[s][d*BCD_W +: BCD_W] + BCD_W'(BCD_ADJ)
          : stage[s][d*BCD_W +: BCD_W];
    end
    logic unused_top;
    assign unused_top  = adj[OUT_W-1];
    assign stage[s+1]  = {adj[OUT_W-2:0], bin[BIN_W-1-s]};
  end

  assign bcd = stage[BIN_W];

  always_comb begin
    if (!$isunknown(bin)) begin
      for (int d = 0; d < DIGITS; d++) begin
        // R6
        digit_range_chk: assert (bcd[d*BCD_W +: BCD_W] <= BCD_W'(9))
          else $error("digit %0d out of range: %0d", d, bcd[d*BCD_W +: BCD_W]);
      end
    end
  end
endmodule

// File: rtl/sbcd_conv.sv
module sbcd_conv
  import bcd_pkg::*;
#(
  parameter int unsigned IN_W    = 16,
  parameter int unsigned FIELD_W = 10,
  parameter int unsigned SHIFT   = 2,
  localparam int unsigned MAG_W  = FIELD_W - 1,
  localparam int unsigned BIN_W  = MAG_W + SHIFT,
  localparam int unsigned DIGITS = 4,
  localparam int unsigned OUT_W  = DIGITS * BCD_W
) (
  input  logic [IN_W-1:0]    sample_in,
  output logic [FIELD_W-1:0] field_out,
  output logic [BCD_W-1:0]   dig_ones,
  output logic [BCD_W-1:0]   dig_tens,
  output logic [BCD_W-1:0]   dig_hundreds,
  output logic [BCD_W-1:0]   dig_thousands,
  output logic               neg_out
);
  localparam logic [FIELD_W-1:0] MIN_CODE = {1'b1, {MAG_W{1'b0}}};

  logic             is_min;
  logic [MAG_W-1:0] mag;
  logic [BIN_W-1:0] scaled;
  logic [OUT_W-1:0] bcd;

  sbcd_field_sign #(.IN_W(IN_W), .FIELD_W(FIELD_W)) u_sign (
    .word_in (sample_in),
    .field   (field_out),
    .is_neg  (neg_out),
    .is_min  (is_min),
    .mag     (mag)
  );

  sbcd_scale #(.MAG_W(MAG_W), .SHIFT(SHIFT)) u_scale (
    .mag        (mag),
    .force_zero (is_min),
    .scaled     (scaled)
  );

  sbcd_dabble #(.BIN_W(BIN_W), .DIGITS(DIGITS)) u_dabble (
    .bin (scaled),
    .bcd (bcd)
  );

  assign dig_ones      = bcd[0*BCD_W +: BCD_W];
  assign dig_tens      = bcd[1*BCD_W +: BCD_W];
  assign dig_hundreds  = bcd[2*BCD_W +: BCD_W];
  assign dig_thousands = bcd[3*BCD_W +: BCD_W];

  always_comb begin
    if (!$isunknown(sample_in)) begin
      // R8
      no_unknown_chk: assert (!$isunknown({field_out, bcd, neg_out}))
        else $error("unknown output for known input");
      // R1
      field_pass_chk: assert (field_out == sample_in[FIELD_W-1:0])
        else $error("field mismatch");
      // R4
      min_code_zero_chk: assert (field_out != MIN_CODE || (bcd == '0 && !neg_out))
        else $error("most negative code not forced to zero");
      // R5
      neg_nonzero_chk: assert (!neg_out || (bcd != '0 && field_out[FIELD_W-1]))
        else $error("negative flag with zero magnitude or positive field");
      // R6
      thousands_cap_chk: assert (dig_thousands <= BCD_W'(2))
        else $error("thousands digit above 2");
    end
  end
endmodule

// File: tb/sbcd_conv_tb.sv
module sbcd_conv_tb;
  logic        clk = 1'b0;
  logic [15:0] sample_in = 16'd0;
  logic [9:0]  field_out;
  logic [3:0]  dig_ones, dig_tens, dig_hundreds, dig_thousands;
  logic        neg_out;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  sbcd_conv u_dut (
    .sample_in     (sample_in),
    .field_out     (field_out),
    .dig_ones      (dig_ones),
    .dig_tens      (dig_tens),
    .dig_hundreds  (dig_hundreds),
    .dig_thousands (dig_thousands),
    .neg_out       (neg_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic int digit_value();
    return int'(dig_thousands) * 1000 + int'(dig_hundreds) * 100 +
           int'(dig_tens) * 10 + int'(dig_ones);
  endfunction

  function automatic int model_value(int code);
    if (code < 512)       return 4 * code;
    else if (code == 512) return 0;
    else                  return 4 * (1024 - code);
  endfunction

  function automatic bit model_neg(int code);
    return (code > 512);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_tests = n_tests + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d (input 0x%04h)", req, got, exp, sample_in);
    end
  endtask

  task automatic apply(logic [15:0] w);
    sample_in = w;
    #3;
  endtask

  task automatic check_code(int code, string req);
    chk(req, digit_value(), model_value(code));
    chk("R5", int'(neg_out), int'(model_neg(code)));
    chk("R1", int'(field_out), code);
    chk("R6", int'(dig_ones <= 9 && dig_tens <= 9 && dig_hundreds <= 9 && dig_thousands <= 2), 1);
    chk("R8", int'($isunknown({field_out, dig_ones, dig_tens, dig_hundreds, dig_thousands, neg_out})), 0);
  endtask

  task automatic t_initial();
    apply(16'h0000);
    check_code(0, "R2");
  endtask

  task automatic t_positive_sweep();
    for (int c = 0; c < 512; c++) begin
      apply(16'(c));
      check_code(c, "R2");
    end
  endtask

  task automatic t_negative_sweep();
    for (int c = 513; c < 1024; c++) begin
      apply(16'(c));
      check_code(c, "R3");
    end
  endtask

  task automatic t_min_code();
    apply(16'd512);
    chk("R4", int'({dig_thousands, dig_hundreds, dig_tens, dig_ones}), 0);
    chk("R4", int'(neg_out), 0);
    apply(16'hFE00);
    chk("R4", int'({dig_thousands, dig_hundreds, dig_tens, dig_ones}), 0);
    chk("R4", int'(neg_out), 0);
  endtask

  task automatic t_extremes();
    apply(16'd511);
    chk("R2", int'(dig_thousands), 2);
    chk("R2", digit_value(), 2044);
    apply(16'd513);
    chk("R3", digit_value(), 2044);
    chk("R3", int'(neg_out), 1);
    apply(16'd1023);
    chk("R3", digit_value(), 4);
    chk("R3", int'(neg_out), 1);
    apply(16'd1);
    chk("R2", digit_value(), 4);
  endtask

  task automatic t_upper_ignored();
    int codes [6] = '{0, 1, 511, 512, 513, 1023};
    logic [5:0] pats [4] = '{6'h3F, 6'h15, 6'h2A, 6'h01};
    foreach (codes[i]) begin
      logic [25:0] base;
      apply(16'(codes[i]));
      base = {field_out, dig_thousands, dig_hundreds, dig_tens, dig_ones};
      for (int p = 0; p < 4; p++) begin
        apply({pats[p], 10'(codes[i])});
        chk("R7", int'({field_out, dig_thousands, dig_hundreds, dig_tens, dig_ones}), int'(base));
        chk("R7", int'(neg_out), int'(model_neg(codes[i])));
      end
    end
  endtask

  initial begin
    #5;
    t_initial();
    t_positive_sweep();
    t_negative_sweep();
    t_min_code();
    t_extremes();
    t_upper_ignored();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule